// File: doc/BRIEF.md
# Crosswise Tree Integer Multiplier

This block multiplies two unsigned integers and returns the full-width product. The product is built as a tree. At the bottom, every pair of 2-bit operand digits is multiplied by a small vertical-and-crosswise cell, and together these cells produce all partial products. Each higher level joins four half-width products into one product of twice the width, using only adders and fixed shifts. There is no array of shift-and-add rows.

The default widths suit floating-point significands: two 53-bit operands give a 106-bit product. Both operands are zero-padded inside the block to the next power of two, which is 64 bits at the default widths. The padded tree therefore yields 128 bits, and the upper 22 of them are always zero and are dropped. One parameter places a register on the product, giving a latency of one clock. With that register left out, the block is purely combinational.

Top module: `xwise_mul`

## Requirements
- R1: With `OUT_REG`=1, `p` equals the unsigned product `a*b` at full `A_W+B_W` width. It is registered on the rising clock edge, so it appears one clock after the operands are sampled. The 53-bit random operand pairs used in the bench are multiplied exactly.
- R2: The 2x2 base rule holds for operands below 4. Bit 0 of the product is a0&b0. Bit 1 is (a1&b0) xor (a0&b1). Bits 3:2 are a1&b1 plus the carry (a1&b0)&(a0&b1). The product of operands below 4 stays below 16.
- R3: If either operand is zero, the product is zero.
- R4: Each operand is zero-padded to the next power-of-two width. The bits of the padded result above `A_W+B_W` are always zero. The output keeps all `A_W+B_W` bits, so for all-ones operands the top bit `p[A_W+B_W-1]` is 1.
- R5: An active-low `rst_n` clears the output register to zero asynchronously, and the register stays zero while `rst_n` is low.
- R6: Single-bit operands 2^i and 2^j give exactly 2^(i+j). Multiplying by 1 returns the other operand unchanged.
- R7: All-ones operands give (2^A_W-1)*(2^B_W-1). At the default widths this is (2^53-1)^2.
- R8: With `OUT_REG`=0, `p` equals `a*b` within the same cycle. Unequal operand widths that are not powers of two are also handled, for example 7x5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | A_W | Unsigned multiplicand |
| b | input | B_W | Unsigned multiplier |
| p | output | A_W+B_W | Unsigned full-width product |

## Verification
On every cycle, the assertions check the following:
- the product against the operands of the previous cycle, or of the same cycle when the output register is left out;
- the zero-operand and unit-operand cases;
- the 4-bit bound on products of small operands;
- that the padded upper result bits are zero;
- that the register is clear during reset.

Only the bench's scenarios can show the following:
- the exact bit pattern of each 2x2 leaf case;
- the exact values at the extremes, namely all-ones and single-bit shifts across the whole width;
- the asynchronous clearing that happens between clock edges;
- exhaustive coverage of an unequal 7x5 combinational instance.

// File: rtl/xwise_mul.sv
module xwise_mul #(
  parameter int A_W     = 53,
  parameter int B_W     = 53,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  function automatic int pow2_ceil(input int n);
    int r;
    r = 2;
    while (r < n) r = r * 2;
    return r;
  endfunction

  localparam int OP_W   = (A_W > B_W) ? A_W : B_W;
  localparam int CORE_W = pow2_ceil(OP_W);
  localparam int LVLS   = $clog2(CORE_W);
  localparam int PW     = A_W + B_W;

  logic [CORE_W-1:0]   a_pad, b_pad;
  logic [2*CORE_W-1:0] core_full;

  assign a_pad = CORE_W'(a);
  assign b_pad = CORE_W'(b);

  for (genvar L = 1; L <= LVLS; L++) begin : g_lvl
    localparam int BW = 1 << L;
    localparam int NS = CORE_W >> L;
    logic [2*BW-1:0] pp [NS*NS];

    for (genvar i = 0; i < NS; i++) begin : g_row
      for (genvar j = 0; j < NS; j++) begin : g_col
        if (L == 1) begin : g_leaf
          logic a0, a1, b0, b1, x0, x1, cr, hi;
          assign a0 = a_pad[2*i];
          assign a1 = a_pad[2*i+1];
          assign b0 = b_pad[2*j];
          assign b1 = b_pad[2*j+1];
          assign x0 = a1 & b0;
          assign x1 = a0 & b1;
          assign cr = x0 & x1;
          assign hi = a1 & b1;
          assign pp[i*NS+j] = {hi & cr, hi ^ cr, x0 ^ x1, a0 & b0};
        end else begin : g_node
          localparam int PS = 2 * NS;
          localparam int H  = BW / 2;
          logic [BW-1:0] ll, lh, hl, hh;
          logic [BW:0]   mid;
          assign ll  = g_lvl[L-1].pp[(2*i)*PS   + 2*j];
          assign lh  = g_lvl[L-1].pp[(2*i)*PS   + 2*j + 1];
          assign hl  = g_lvl[L-1].pp[(2*i+1)*PS + 2*j];
          assign hh  = g_lvl[L-1].pp[(2*i+1)*PS + 2*j + 1];
          assign mid = {1'b0, lh} + {1'b0, hl};
          assign pp[i*NS+j] = {hh, ll} + {{(BW-H-1){1'b0}}, mid, {H{1'b0}}};
        end
      end
    end
  end

  assign core_full = g_lvl[LVLS].pp[0];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p <= '0;
      else        p <= core_full[PW-1:0];
    end
  end else begin : g_comb
    assign p = core_full[PW-1:0];
  end
endmodule

module xwise_mul_chk #(
  parameter int A_W     = 53,
  parameter int B_W     = 53,
  parameter bit OUT_REG = 1'b1,
  parameter int CORE_W  = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [A_W-1:0]      a,
  input logic [B_W-1:0]      b,
  input logic [A_W+B_W-1:0]  p,
  input logic [2*CORE_W-1:0] core_full
);
  localparam int PW = A_W + B_W;
  logic [PW-1:0] ax, bx;
  assign ax = PW'(a);
  assign bx = PW'(b);

  if (OUT_REG) begin : g_seq
    p_prod_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> p == $past(ax * bx));
    p_small_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ax < 4 && bx < 4) |=> p < 16);
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ax == 0 || bx == 0) |=> p == 0);
    p_rst_clear_r5: assert property (@(posedge clk)
      !rst_n |=> p == 0);
    p_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bx == 1) |=> p == $past(ax));
  end else begin : g_cmb
    p_prod_r8: assert property (@(posedge clk) disable iff (!rst_n)
      p == ax * bx);
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ax == 0 || bx == 0) |-> p == 0);
  end

  if (2*CORE_W > PW) begin : g_pad
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_full[2*CORE_W-1:PW] == '0);
  end
endmodule

bind xwise_mul xwise_mul_chk #(
  .A_W(A_W), .B_W(B_W), .OUT_REG(OUT_REG), .CORE_W(CORE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p), .core_full(core_full)
);

// File: tb/tb_xwise_mul.sv
module tb_xwise_mul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [52:0]  a = '0, b = '0;
  logic [105:0] p;
  logic [6:0]   sa = '0;
  logic [4:0]   sb = '0;
  logic [11:0]  sp;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xwise_mul dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p));
  xwise_mul #(.A_W(7), .B_W(5), .OUT_REG(1'b0)) dut_cmb
    (.clk(clk), .rst_n(rst_n), .a(sa), .b(sb), .p(sp));

  task automatic check(input string req, input logic [105:0] got, input logic [105:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [105:0] ref_mul(input logic [52:0] x, input logic [52:0] y);
    return {53'b0, x} * {53'b0, y};
  endfunction

  task automatic apply(input logic [52:0] x, input logic [52:0] y);
    @(negedge clk);
    a = x; b = y;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R5 reset clear", p, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_leaf;
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        logic [3:0] e;
        logic c1, c2;
        c1 = x[1] & y[0];
        c2 = x[0] & y[1];
        e[0] = x[0] & y[0];
        e[1] = c1 ^ c2;
        e[3:2] = {1'b0, x[1] & y[1]} + {1'b0, c1 & c2};
        apply(53'(x), 53'(y));
        check("R2 leaf rule", p, 106'(e));
      end
  endtask

  task automatic t_zero;
    apply(53'h1a2b3c4d5e6f7, '0);
    check("R3 zero b", p, '0);
    apply('0, '1);
    check("R3 zero a", p, '0);
  endtask

  task automatic t_ones;
    apply('1, '1);
    check("R7 all ones", p, ref_mul('1, '1));
    check("R4 top bit kept", 106'(p[105]), 106'd1);
  endtask

  task automatic t_single;
    for (int i = 0; i < 53; i += 4) begin
      apply(53'd1 << i, 53'd1 << (52 - i));
      check("R6 single bits", p, 106'd1 << 52);
    end
    apply(53'h10_0000_0000_0001, 53'd1);
    check("R6 unit operand", p, 106'h10_0000_0000_0001);
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      logic [52:0] x, y;
      x = 53'({$urandom(), $urandom()});
      y = 53'({$urandom(), $urandom()});
      apply(x, y);
      check("R1 random product", p, ref_mul(x, y));
    end
  endtask

  task automatic t_async_reset;
    apply(53'h123456789, 53'h0abcdef);
    check("R1 before reset", p, ref_mul(53'h123456789, 53'h0abcdef));
    #3 rst_n = 1'b0;
    #1 check("R5 async clear", p, '0);
    @(negedge clk);
    check("R5 held in reset", p, '0);
    rst_n = 1'b1;
    apply(53'd3, 53'd5);
    check("R1 after reset", p, 106'd15);
  endtask

  task automatic t_comb;
    for (int x = 0; x < 128; x++)
      for (int y = 0; y < 32; y++) begin
        sa = 7'(x); sb = 5'(y);
        #1;
        check("R8 comb 7x5", 106'(sp), 106'(x * y));
      end
    check("R4 comb top bit", 106'(sp[11]), 106'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_leaf();
    t_zero();
    t_ones();
    t_single();
    t_random();
    t_async_reset();
    t_comb();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule